// File: doc/BRIEF.md
# MFM interval-measuring data decoder

This block turns a raw MFM read stream into a serial stream of decoded data bits. It uses no phase-locked loop. A fast free-running system clock, nominally 50 MHz, times the gap between successive flux-transition edges. Each gap is sorted into one of three legal lengths: short (about one bit cell), long (about one and a half cells) or very long (about two cells). A three-state decoder then turns that sequence of lengths into data bits. Each bit is presented with a one-cycle valid strobe.

Before it produces any data, the decoder must acquire lock. It waits for an unbroken run of short gaps, the kind a zero-filled preamble produces, and then starts in the state that follows a cell-boundary transition. The last cell of such a run is always known to be zero but is only sent out once the next gap is measured, so the output runs one interval behind the input. A gap outside every legal length, or a very long gap where it cannot occur, raises a one-cycle sync-error pulse and returns the decoder to lock acquisition. Address-mark search, CRC and sector framing belong to the blocks downstream.

Top module: `mfm_interval_decoder`

## Requirements
- R1: While reset is held and just after it is released, `bit_valid`, `sync_err` and `locked` are all low.
- R2: `rd_in` passes through a two-flop synchronizer, and only its rising edges mark transitions; a falling edge neither starts nor ends an interval. The first bit that a transition completes shows on `bit_valid` at the fourth rising clock edge after `rd_in` rises.
- R3: An interval is the number of clock cycles between two successive rising edges. With the default limits, 1 to 14 is short, 15 to 20 is long and 21 to 27 is very long. 28 or more, including a saturated counter, is out of class and raises `sync_err`. The first edge after reset only starts timing.
- R4: After reset or a sync error the decoder is unlocked. It emits no bits until 16 consecutive short intervals arrive, and any long or very long interval restarts that count. After the 16th short interval `locked` goes high, the decoder is in the boundary state, and no bit is emitted for that interval.
- R5: In the boundary state, which follows a transition at the start of a zero cell, the outcomes are: short emits 0 and stays; long emits 0 then 1 and moves to the mid-cell state; very long is a sync error.
- R6: In the mid-cell state, which follows a transition in the middle of a one cell, the outcomes are: short emits 1 and stays; long emits 0 and moves to the boundary state; very long emits 0 then 1 and stays.
- R7: A two-bit result appears as two `bit_valid` pulses in consecutive cycles, in transmission order, with the earlier bit first.
- R8: For an MFM stream of 17 zero cells, then a payload, then two zero cells, the output is exactly 0, the payload, then 0, with no sync error and `locked` still high. A repeating 100 payload, which gives nothing but long intervals, decodes correctly and stays locked.
- R9: An out-of-class interval, or a very long interval in the boundary state, pulses `sync_err` for one cycle and clears `locked` in the next cycle. It emits no bit and discards the held bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock that times the intervals |
| rst | input | 1 | Synchronous reset, active high |
| rd_in | input | 1 | Raw MFM read data, asynchronous, one pulse per flux transition |
| bit_valid | output | 1 | One-cycle strobe marking a decoded bit |
| bit_data | output | 1 | Decoded bit, valid while `bit_valid` is high |
| sync_err | output | 1 | One-cycle pulse on an interval that is illegal in the current state |
| locked | output | 1 | High while the decoder is in the boundary or mid-cell state |

## Verification
The assertions assume that successive rising edges of `rd_in` are at least four clock cycles apart. Under that assumption a second bit never collides with a new interval result, and a bit strobe never coincides with an error caused by the following interval. The stimulus keeps within this bound: every transition is a pulse at least three cycles wide, and every gap the tasks drive is twelve cycles or more. Timing is checked by counting clock edges from the cycle in which `rd_in` is raised. Bit values are checked against a model, written inside the bench, that encodes the payload into transition positions.

// File: rtl/mfm_dec_pkg.sv
package mfm_dec_pkg;

    // Length class of one edge-to-edge interval
    typedef enum logic [1:0] {
        IV_SHORT = 2'd0,
        IV_LONG  = 2'd1,
        IV_VLONG = 2'd2,
        IV_BAD   = 2'd3
    } iv_class_t;

    // Decoder phase: hunting for lock, after a mid-cell transition,
    // or after a transition on a cell boundary between two zeros
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_MID  = 2'd1,
        ST_EDGE = 2'd2
    } dec_state_t;

endpackage

// File: rtl/mfm_edge_sync.sv
module mfm_edge_sync #(
    parameter int  SYNC_STAGES = 2,
    parameter bit  RISING      = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_in,
    output logic edge_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        synced;

    assign synced = st_q.chain[SYNC_STAGES-1];

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], rd_in};
        st_d.last  = synced;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Polarity of the transition that marks a flux reversal
    generate
        if (RISING) begin : g_rise
            assign edge_o = synced & ~st_q.last;
        end else begin : g_fall
            assign edge_o = ~synced & st_q.last;
        end
    endgenerate

endmodule

// File: rtl/mfm_interval_timer.sv
module mfm_interval_timer
    import mfm_dec_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int SHORT_LIM = 15,
    parameter int LONG_LIM  = 21,
    parameter int VLONG_LIM = 28
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_i,
    output logic      iv_valid_o,
    output iv_class_t iv_class_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LIM);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LIM);
    localparam logic [CNT_W-1:0] VLONG_C = CNT_W'(VLONG_LIM);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             valid;
        iv_class_t        cls;
    } tmr_state_t;

    tmr_state_t tm_d, tm_q;

    function automatic iv_class_t classify(input logic [CNT_W-1:0] c);
        iv_class_t r;
        if (c < SHORT_C) begin
            r = IV_SHORT;
        end else if (c < LONG_C) begin
            r = IV_LONG;
        end else if (c < VLONG_C) begin
            r = IV_VLONG;
        end else begin
            r = IV_BAD;
        end
        return r;
    endfunction

    always_comb begin
        tm_d       = tm_q;
        tm_d.valid = 1'b0;
        if (edge_i) begin
            // The first edge after reset only arms the timer
            if (tm_q.armed) begin
                tm_d.valid = 1'b1;
                tm_d.cls   = classify(tm_q.cnt);
            end
            tm_d.cnt   = ONE_C;
            tm_d.armed = 1'b1;
        end else if (tm_q.cnt != CNT_MAX) begin
            tm_d.cnt = tm_q.cnt + ONE_C;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '{cnt: '0, armed: 1'b0, valid: 1'b0, cls: IV_SHORT};
        end else begin
            tm_q <= tm_d;
        end
    end

    assign iv_valid_o = tm_q.valid;
    assign iv_class_o = tm_q.cls;

endmodule

// File: rtl/mfm_bit_fsm.sv
module mfm_bit_fsm
    import mfm_dec_pkg::*;
#(
    parameter int LOCK_RUN = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      iv_valid_i,
    input  iv_class_t iv_class_i,
    output logic      bit_valid_o,
    output logic      bit_data_o,
    output logic      sync_err_o,
    output logic      locked_o
);

    localparam int             RUN_W    = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

    typedef struct packed {
        dec_state_t       st;
        logic [RUN_W-1:0] run;
        logic             out_v;
        logic             out_d;
        logic             hold_v;
        logic             hold_d;
        logic             err;
    } fsm_state_t;

    fsm_state_t fs_d, fs_q;

    always_comb begin
        fs_d       = fs_q;
        fs_d.out_v = 1'b0;
        fs_d.err   = 1'b0;

        // Second bit of a pair leaves one cycle after the first
        if (fs_q.hold_v) begin
            fs_d.out_v  = 1'b1;
            fs_d.out_d  = fs_q.hold_d;
            fs_d.hold_v = 1'b0;
        end

        if (iv_valid_i) begin
            unique case (fs_q.st)
                ST_HUNT: begin
                    if (iv_class_i == IV_SHORT) begin
                        if (fs_q.run == RUN_LAST) begin
                            fs_d.st  = ST_EDGE;
                            fs_d.run = '0;
                        end else begin
                            fs_d.run = fs_q.run + 1'b1;
                        end
                    end else begin
                        fs_d.run = '0;
                        fs_d.err = (iv_class_i == IV_BAD);
                    end
                end
                ST_MID: begin
                    unique case (iv_class_i)
                        IV_SHORT: begin
                            fs_d.out_v = 1'b1;
                            fs_d.out_d = 1'b1;
                        end
                        IV_LONG: begin
                            fs_d.out_v = 1'b1;
                            fs_d.out_d = 1'b0;
                            fs_d.st    = ST_EDGE;
                        end
                        IV_VLONG: begin
                            fs_d.out_v  = 1'b1;
                            fs_d.out_d  = 1'b0;
                            fs_d.hold_v = 1'b1;
                            fs_d.hold_d = 1'b1;
                        end
                        default: fs_d.err = 1'b1;
                    endcase
                end
                ST_EDGE: begin
                    unique case (iv_class_i)
                        IV_SHORT: begin
                            fs_d.out_v = 1'b1;
                            fs_d.out_d = 1'b0;
                        end
                        IV_LONG: begin
                            fs_d.out_v  = 1'b1;
                            fs_d.out_d  = 1'b0;
                            fs_d.hold_v = 1'b1;
                            fs_d.hold_d = 1'b1;
                            fs_d.st     = ST_MID;
                        end
                        default: fs_d.err = 1'b1;
                    endcase
                end
                default: begin
                    fs_d.st  = ST_HUNT;
                    fs_d.run = '0;
                end
            endcase

            // Loss of sync drops any pending bit and restarts the hunt
            if (fs_d.err) begin
                fs_d.st     = ST_HUNT;
                fs_d.run    = '0;
                fs_d.out_v  = 1'b0;
                fs_d.hold_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= '{st: ST_HUNT, run: '0, out_v: 1'b0, out_d: 1'b0,
                      hold_v: 1'b0, hold_d: 1'b0, err: 1'b0};
        end else begin
            fs_q <= fs_d;
        end
    end

    assign bit_valid_o = fs_q.out_v;
    assign bit_data_o  = fs_q.out_d;
    assign sync_err_o  = fs_q.err;
    assign locked_o    = (fs_q.st != ST_HUNT);

endmodule

// File: rtl/mfm_interval_decoder.sv
module mfm_interval_decoder
    import mfm_dec_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6,
    parameter int SHORT_LIM   = 15,
    parameter int LONG_LIM    = 21,
    parameter int VLONG_LIM   = 28,
    parameter int LOCK_RUN    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_in,
    output logic bit_valid,
    output logic bit_data,
    output logic sync_err,
    output logic locked
);

    logic      flux_edge;
    logic      iv_valid;
    iv_class_t iv_class;

    mfm_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .RISING      (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rd_in  (rd_in),
        .edge_o (flux_edge)
    );

    mfm_interval_timer #(
        .CNT_W     (CNT_W),
        .SHORT_LIM (SHORT_LIM),
        .LONG_LIM  (LONG_LIM),
        .VLONG_LIM (VLONG_LIM)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (flux_edge),
        .iv_valid_o (iv_valid),
        .iv_class_o (iv_class)
    );

    mfm_bit_fsm #(
        .LOCK_RUN (LOCK_RUN)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .iv_valid_i  (iv_valid),
        .iv_class_i  (iv_class),
        .bit_valid_o (bit_valid),
        .bit_data_o  (bit_data),
        .sync_err_o  (sync_err),
        .locked_o    (locked)
    );

endmodule

// File: rtl/mfm_interval_decoder_chk.sv
module mfm_interval_decoder_chk
    import mfm_dec_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      iv_valid,
    input iv_class_t iv_class,
    input logic      bit_valid,
    input logic      sync_err,
    input logic      locked
);

    // An error always leaves the decoder unlocked in the next cycle
    assert_err_unlocks_R9: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !locked);

    // Errors only come from a measured interval
    assert_err_after_interval_R9: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> $past(iv_valid));

    // An out-of-class interval always reports an error
    assert_bad_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (iv_valid && iv_class == IV_BAD) |=> sync_err);

    // No data while hunting for lock
    assert_bit_needs_lock_R4: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> locked);

    // Lock is only gained on a short interval
    assert_lock_on_short_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(iv_valid) && $past(iv_class) == IV_SHORT));

    // A bit follows an interval directly, or follows the first bit of a pair
    assert_bit_follows_interval_R7: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> ($past(iv_valid) || $past(bit_valid)));

endmodule

bind mfm_interval_decoder mfm_interval_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iv_valid  (iv_valid),
    .iv_class  (iv_class),
    .bit_valid (bit_valid),
    .sync_err  (sync_err),
    .locked    (locked)
);

// File: tb/sim_mfm_interval_decoder.sv
`timescale 1ns/1ps
module sim_mfm_interval_decoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_in = 1'b0;
    logic bit_valid, bit_data, sync_err, locked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ng = 0;
    int nerr = 0;
    bit got [0:255];
    int gt  [0:255];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mfm_interval_decoder u0 (
        .clk       (clk),
        .rst       (rst),
        .rd_in     (rd_in),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .sync_err  (sync_err),
        .locked    (locked)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (bit_valid === 1'b1 && ng < 256) begin
            got[ng] = bit_data;
            gt[ng]  = cyc;
            ng++;
        end
        if (sync_err === 1'b1) nerr++;
    end

    task automatic chk_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rd_in = 1'b0;
        ng = 0;
        nerr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One rising edge, held high hi cycles; next edge comes gap cycles later
    task automatic pulse(int gap, int hi);
        rd_in = 1'b1;
        repeat (hi) @(negedge clk);
        rd_in = 1'b0;
        repeat (gap - hi) @(negedge clk);
    endtask

    // 16 edges 12 cycles apart; the next edge completes the 16th short interval
    task automatic preamble(int hi);
        repeat (16) pulse(12, hi);
    endtask

    task automatic check_bits(string req, logic [63:0] e, int n);
        chk_eq(req, "bit count", ng, n);
        for (int i = 0; i < n && i < ng; i++) begin
            chk_eq(req, $sformatf("bit %0d", i), int'(got[i]), int'(e[i]));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_eq("R1", "bit_valid in reset", int'(bit_valid), 0);
        chk_eq("R1", "locked in reset", int'(locked), 0);
        do_reset();
        repeat (5) @(negedge clk);
        chk_eq("R1", "bit_valid after reset", int'(bit_valid), 0);
        chk_eq("R1", "sync_err after reset", int'(sync_err), 0);
        chk_eq("R1", "locked after reset", int'(locked), 0);
    endtask

    task automatic t_hunt();
        do_reset();
        repeat (8) pulse(12, 3);
        pulse(18, 3);                 // long interval restarts the run
        repeat (15) pulse(12, 3);
        pulse(12, 3);                 // 15 shorts since the long one
        chk_eq("R4", "locked after 15 shorts", int'(locked), 0);
        chk_eq("R4", "no error on long while hunting", nerr, 0);
        pulse(40, 3);                 // 16th short
        chk_eq("R4", "locked after 16 shorts", int'(locked), 1);
        chk_eq("R4", "no bits while hunting or on lock", ng, 0);
    endtask

    task automatic t_latency();
        do_reset();
        preamble(8);                  // wide pulses: falling edges must not count
        pulse(12, 8);                 // completes 16th short -> lock
        rd_in = 1'b1;                 // ends a 12 interval from boundary -> "0"
        repeat (3) @(negedge clk);
        chk_eq("R2", "bit_valid 3 edges after rise", int'(bit_valid), 0);
        @(negedge clk);
        chk_eq("R2", "bit_valid 4 edges after rise", int'(bit_valid), 1);
        chk_eq("R2", "bit_data first bit", int'(bit_data), 0);
        repeat (10) @(negedge clk);   // held high 14 cycles
        rd_in = 1'b0;
        repeat (4) @(negedge clk);    // next edge 18 cycles after -> long
        pulse(40, 3);
        check_bits("R2", 64'b100, 3);
        chk_eq("R2", "no sync error with wide pulses", nerr, 0);
    endtask

    task automatic t_boundary_state();
        do_reset();
        preamble(3);
        pulse(14, 3);                 // lock edge; 14 short from boundary -> 0
        pulse(15, 3);                 // 15 long from boundary -> 0 1
        pulse(40, 3);
        check_bits("R3 R5", 64'b100, 3);
        if (ng >= 3) begin
            chk_eq("R7", "pair second bit one cycle after first", gt[2] - gt[1], 1);
            checks++;
            if (gt[1] - gt[0] < 2) begin
                errors++;
                $display("FAIL R7 separate results adjacent: got %0d expected >=2",
                         gt[1] - gt[0]);
            end
        end
        chk_eq("R5", "still locked", int'(locked), 1);
    endtask

    task automatic t_mid_state();
        do_reset();
        preamble(3);
        pulse(18, 3);                 // B long  -> 0 1, to A
        pulse(21, 3);                 // A vlong -> 0 1
        pulse(27, 3);                 // A vlong -> 0 1
        pulse(20, 3);                 // A long  -> 0, to B
        pulse(12, 3);                 // B short -> 0
        pulse(40, 3);
        check_bits("R3 R6", 64'b00101010, 8);
        chk_eq("R6", "no sync error", nerr, 0);
        chk_eq("R6", "still locked", int'(locked), 1);
    endtask

    task automatic t_errors();
        do_reset();
        preamble(3);
        pulse(18, 3);                 // -> 0 1
        pulse(28, 3);                 // out of class
        pulse(40, 3);
        check_bits("R9", 64'b10, 2);
        chk_eq("R9", "one sync error on 28", nerr, 1);
        chk_eq("R9", "unlocked after error", int'(locked), 0);

        do_reset();
        preamble(3);
        pulse(21, 3);                 // very long in boundary state
        pulse(40, 3);
        chk_eq("R5", "vlong in boundary gives error", nerr, 1);
        chk_eq("R9", "held bit discarded", ng, 0);
        chk_eq("R9", "unlocked after boundary error", int'(locked), 0);
    endtask

    task automatic t_stream(string req, logic [63:0] pay, int p);
        int pos [0:255];
        int ne = 0;
        bit prev = 1'b0;
        int ncell = 17 + p + 2;
        logic [63:0] e = '0;
        do_reset();
        for (int i = 0; i < ncell; i++) begin
            bit cur;
            cur = (i >= 17 && i < 17 + p) ? pay[i - 17] : 1'b0;
            if (cur) begin
                pos[ne] = 12 * i + 6;
                ne++;
            end else if (!prev) begin
                pos[ne] = 12 * i;
                ne++;
            end
            prev = cur;
        end
        for (int j = 0; j < ne; j++) begin
            pulse((j < ne - 1) ? pos[j + 1] - pos[j] : 40, 3);
        end
        for (int i = 0; i < p; i++) e[i + 1] = pay[i];
        check_bits(req, e, p + 2);
        chk_eq(req, "no sync error", nerr, 0);
        chk_eq(req, "locked at end", int'(locked), 1);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hunt();
        t_latency();
        t_boundary_state();
        t_mid_state();
        t_errors();
        t_stream("R8 mixed", 64'h5A3C9, 20);
        t_stream("R8 ones", 64'hFFF, 12);
        t_stream("R8 long run", 64'h249249, 24);
        t_stream("R8 sparse", 64'h10421, 18);
        finished = 1'b1;
        report();
        $finish;
    end

endmodule